// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a store path that does not allocate into a cache and the memory write interface. It gathers byte-enabled stores that fall into one aligned line (32 bytes by default) and holds them, so that a later store to a byte already held replaces the earlier value inside the buffer. The earlier value never reaches memory. Nothing gathered is kept as cached data. The whole line leaves as one masked burst when a trigger occurs.

There are three triggers. The first is the line becoming completely written. The second is a store that names a different line. The third is an explicit drain request. While a drain is outstanding the store port is held off. Once memory accepts the burst, the buffer is empty again.

The controller has three states:

- **EMPTY**: no line is open.
- **GATHER**: a line is open and collecting bytes.
- **DRAIN**: the burst is offered to memory.

The transitions are:

- **EMPTY→GATHER**: a store with at least one enabled byte is accepted. It opens its line.
- **EMPTY→DRAIN**: this happens only when a single store fills a whole line.
- **GATHER→GATHER**: a store to the open line merges in and leaves bytes still missing.
- **GATHER→DRAIN**: this is taken on a flush request, on a store with enabled bytes to another line, or on a merging store that completes the line.
- **DRAIN→DRAIN**: memory is not yet ready.
- **DRAIN→EMPTY**: memory accepts the burst.

Top module: `write_combine_buffer`

## Requirements
- R1: After reset, `mem_valid` is 0 and, with `flush` low, `st_ready` is 1. The buffer holds no bytes.
- R2: A store is accepted on a clock edge where `st_valid` and `st_ready` are both 1. The store address is split into three fields:
  - bits [ADDR_W-1:5] select the line;
  - bits [4:3] select the 8-byte slot;
  - bits [2:0] are ignored.
  
  Enabled bytes are merged into the held line, and a later store to a byte replaces its earlier value. While the line is neither full nor flushed, `mem_valid` stays 0.
- R3: When an accepted store makes all 32 bytes of the line valid, `mem_valid` is 1 in the next cycle with `mem_mask` all ones. No flush is needed.
- R4: In GATHER, a store with enabled bytes to a different line is not accepted. The open line is drained first, and that store is then accepted as the first store of a new line.
- R5: `flush` high forces `st_ready` to 0. A flush in GATHER starts a drain on the next cycle. A flush while the buffer is empty produces no memory write.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, the values of `mem_valid`, `mem_addr`, `mem_mask` and `mem_data` are held unchanged, and `st_ready` is 0.
- R7: The burst fields are laid out as follows:
  - `mem_addr` is the line address with its low 5 bits zero.
  - `mem_mask` bit i is 1 exactly when line byte i was written. Store lane j of slot s is line byte 8*s+j.
  - `mem_data` bits [8i+7:8i] carry the newest value of byte i, or zero when mask bit i is 0.
  - `mem_mask` is never zero.
- R8: After memory accepts a burst, `mem_valid` is 0 in the next cycle and the buffer is empty. A store to the same line then starts a fresh mask, and bytes already sent are not repeated.
- R9: A store whose byte enables are all zero is accepted whenever the buffer is not draining and no flush is pending. It writes nothing, opens no line and triggers no drain, even when it names another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 8*STORE_BYTES | Store data, lane j in bits [8j+7:8j] |
| st_be | input | STORE_BYTES | Per-lane byte enables |
| flush | input | 1 | Request to drain the open line |
| mem_valid | output | 1 | Burst offered to memory |
| mem_ready | input | 1 | Memory accepts the burst |
| mem_addr | output | ADDR_W | Line-aligned burst address |
| mem_data | output | 8*LINE_BYTES | Line data, byte i in bits [8i+7:8i] |
| mem_mask | output | LINE_BYTES | Per-byte write mask |

## Verification
The bench targets these corner cases and the failure each one would expose:

- **Overwrite of a held byte.** A buffer that failed to merge would send the stale value or split the line into two bursts.
- **Line completed without a flush.** A missing full detector would leave `mem_valid` low and the line stuck.
- **Store to a new line arriving mid-gather.** A design that accepted it early would corrupt the open line or drop the store.
- **Flush when nothing is held.** A careless design would emit a burst with an empty mask.
- **Memory stalling during a drain.** Changing burst fields would show up on the compared outputs.
- **Zero-enable store to a foreign line.** This would expose a design that drained spuriously or reopened a line with no bytes.
- **Rewriting a line right after its drain.** A mask that was not cleared would resend old bytes.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    typedef enum logic [1:0] {
        WCB_EMPTY  = 2'd0,
        WCB_GATHER = 2'd1,
        WCB_DRAIN  = 2'd2
    } wcb_state_e;
endpackage

// File: rtl/wcb_addr_split.sv
module wcb_addr_split #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int STORE_BYTES = 8,
    localparam int LINE_OFF   = $clog2(LINE_BYTES),
    localparam int STORE_OFF  = $clog2(STORE_BYTES),
    localparam int SLOTS      = LINE_BYTES / STORE_BYTES,
    localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int TAG_W      = ADDR_W - LINE_OFF
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [STORE_BYTES-1:0] be,
    input  logic [TAG_W-1:0]       open_tag,
    output logic [TAG_W-1:0]       tag,
    output logic [SLOT_W-1:0]      slot,
    output logic                   same_line,
    output logic                   has_bytes
);
    assign tag       = addr[ADDR_W-1:LINE_OFF];
    assign same_line = (tag == open_tag);
    assign has_bytes = |be;

    generate
        if (SLOTS > 1) begin : g_slot
            assign slot = addr[LINE_OFF-1:STORE_OFF];
        end else begin : g_one_slot
            logic unused_slot_bits;
            assign unused_slot_bits = ^addr[LINE_OFF-1:0];
            assign slot = '0;
        end
        if (STORE_OFF > 0 && SLOTS > 1) begin : g_lane_bits
            logic unused_lane_bits;
            assign unused_lane_bits = ^addr[STORE_OFF-1:0];
        end
    endgenerate
endmodule

// File: rtl/wcb_line_store.sv
module wcb_line_store #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int STORE_BYTES = 8,
    localparam int LINE_OFF   = $clog2(LINE_BYTES),
    localparam int SLOTS      = LINE_BYTES / STORE_BYTES,
    localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int TAG_W      = ADDR_W - LINE_OFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     open_line,
    input  logic                     wr_en,
    input  logic                     clear,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [SLOT_W-1:0]        wr_slot,
    input  logic [8*STORE_BYTES-1:0] wr_data,
    input  logic [STORE_BYTES-1:0]   wr_be,
    output logic [TAG_W-1:0]         tag_q,
    output logic [LINE_BYTES-1:0]    mask_q,
    output logic [8*LINE_BYTES-1:0]  data_out,
    output logic                     full_next
);
    logic [LINE_BYTES-1:0] hit;
    logic [LINE_BYTES-1:0] mask_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else if (open_line) begin
            tag_q <= wr_tag;
        end
    end

    generate
        for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
            localparam int SLOT_IDX = i / STORE_BYTES;
            localparam int LANE_IDX = i % STORE_BYTES;
            logic [7:0] byte_q;

            assign hit[i] = wr_en && (wr_slot == SLOT_W'(SLOT_IDX)) && wr_be[LANE_IDX];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mask_q[i] <= 1'b0;
                end else if (clear) begin
                    mask_q[i] <= 1'b0;
                end else if (hit[i]) begin
                    mask_q[i] <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (hit[i]) begin
                    byte_q <= wr_data[8*LANE_IDX +: 8];
                end
            end

            assign mask_next[i]      = mask_q[i] | hit[i];
            assign data_out[8*i +: 8] = mask_q[i] ? byte_q : 8'h00;
        end
    endgenerate

    assign full_next = &mask_next;
endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl
    import wcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic st_valid,
    input  logic st_has_bytes,
    input  logic st_same_line,
    input  logic flush,
    input  logic full_next,
    input  logic mem_ready,
    output logic st_ready,
    output logic wr_en,
    output logic open_line,
    output logic clear,
    output logic mem_valid
);
    wcb_state_e state_q;
    wcb_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WCB_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WCB_EMPTY: begin
                if (wr_en) begin
                    state_d = full_next ? WCB_DRAIN : WCB_GATHER;
                end
            end
            WCB_GATHER: begin
                if (flush) begin
                    state_d = WCB_DRAIN;
                end else if (st_valid && st_has_bytes && !st_same_line) begin
                    state_d = WCB_DRAIN;
                end else if (wr_en && full_next) begin
                    state_d = WCB_DRAIN;
                end
            end
            WCB_DRAIN: begin
                if (mem_ready) begin
                    state_d = WCB_EMPTY;
                end
            end
            default: state_d = WCB_EMPTY;
        endcase
    end

    always_comb begin
        st_ready  = 1'b0;
        open_line = 1'b0;
        clear     = 1'b0;
        mem_valid = 1'b0;
        unique case (state_q)
            WCB_EMPTY: begin
                st_ready  = !flush;
                open_line = st_valid && !flush && st_has_bytes;
            end
            WCB_GATHER: begin
                st_ready = !flush && (!st_has_bytes || st_same_line);
            end
            WCB_DRAIN: begin
                mem_valid = 1'b1;
                clear     = mem_ready;
            end
            default: ;
        endcase
        wr_en = st_valid && st_ready && st_has_bytes;
    end
endmodule

// File: rtl/write_combine_buffer.sv
module write_combine_buffer #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int STORE_BYTES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     st_valid,
    output logic                     st_ready,
    input  logic [ADDR_W-1:0]        st_addr,
    input  logic [8*STORE_BYTES-1:0] st_data,
    input  logic [STORE_BYTES-1:0]   st_be,
    input  logic                     flush,
    output logic                     mem_valid,
    input  logic                     mem_ready,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [8*LINE_BYTES-1:0]  mem_data,
    output logic [LINE_BYTES-1:0]    mem_mask
);
    localparam int LINE_OFF = $clog2(LINE_BYTES);
    localparam int SLOTS    = LINE_BYTES / STORE_BYTES;
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int TAG_W    = ADDR_W - LINE_OFF;

    logic [TAG_W-1:0]  st_tag;
    logic [TAG_W-1:0]  open_tag;
    logic [SLOT_W-1:0] st_slot;
    logic              same_line;
    logic              has_bytes;
    logic              wr_en;
    logic              open_line;
    logic              clear;
    logic              full_next;

    wcb_addr_split #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .STORE_BYTES(STORE_BYTES)
    ) u_split (
        .addr(st_addr), .be(st_be), .open_tag(open_tag),
        .tag(st_tag), .slot(st_slot), .same_line(same_line), .has_bytes(has_bytes)
    );

    wcb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_has_bytes(has_bytes),
        .st_same_line(same_line), .flush(flush), .full_next(full_next),
        .mem_ready(mem_ready), .st_ready(st_ready), .wr_en(wr_en),
        .open_line(open_line), .clear(clear), .mem_valid(mem_valid)
    );

    wcb_line_store #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .STORE_BYTES(STORE_BYTES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .open_line(open_line), .wr_en(wr_en),
        .clear(clear), .wr_tag(st_tag), .wr_slot(st_slot), .wr_data(st_data),
        .wr_be(st_be), .tag_q(open_tag), .mask_q(mem_mask), .data_out(mem_data),
        .full_next(full_next)
    );

    assign mem_addr = {open_tag, {LINE_OFF{1'b0}}};
endmodule

// File: rtl/wcb_props.sv
module wcb_props #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_ready,
    input logic                    flush,
    input logic                    mem_valid,
    input logic                    mem_ready,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [8*LINE_BYTES-1:0] mem_data,
    input logic [LINE_BYTES-1:0]   mem_mask
);
    a_r6_burst_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_mask) && $stable(mem_data));

    a_r6_port_closed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !st_ready);

    a_r5_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !st_ready);

    a_r8_gap_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid);

    a_r7_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_mask != '0));
endmodule

bind write_combine_buffer wcb_props #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_props (
    .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .flush(flush),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_mask(mem_mask)
);

// File: tb/write_combine_buffer_tb.sv
`timescale 1ns/1ps
module write_combine_buffer_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic         st_ready;
    logic [31:0]  st_addr = '0;
    logic [63:0]  st_data = '0;
    logic [7:0]   st_be = '0;
    logic         flush = 1'b0;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [31:0]  mem_addr;
    logic [255:0] mem_data;
    logic [31:0]  mem_mask;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int drains = 0;

    always #4 clk = ~clk;

    write_combine_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .flush(flush),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_mask(mem_mask)
    );

    task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 empty, 1 gathering, 2 draining
    int          ms = 0;
    logic [7:0]  mb [32];
    logic [31:0] mm = '0;
    logic [26:0] ml = '0;

    function automatic bit exp_ready();
        return !flush && (ms == 0 || (ms == 1 && (st_be == 0 || st_addr[31:5] == ml)));
    endfunction

    function automatic logic [255:0] exp_data();
        logic [255:0] d = '0;
        for (int i = 0; i < 32; i++) if (mm[i]) d[8*i +: 8] = mb[i];
        return d;
    endfunction

    task automatic model_merge();
        for (int j = 0; j < 8; j++) begin
            if (st_be[j]) begin
                mb[st_addr[4:3]*8 + j] = st_data[8*j +: 8];
                mm[st_addr[4:3]*8 + j] = 1'b1;
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ms = 0; mm = '0; ml = '0;
        end else begin
            bit acc;
            acc = st_valid && exp_ready();
            if (mem_valid && mem_ready) drains++;
            case (ms)
                0: if (acc && st_be != 0) begin
                       ml = st_addr[31:5];
                       model_merge();
                       ms = (mm == '1) ? 2 : 1;
                   end
                1: if (flush) ms = 2;
                   else if (st_valid && st_be != 0 && st_addr[31:5] != ml) ms = 2;
                   else if (acc && st_be != 0) begin
                       model_merge();
                       if (mm == '1) ms = 2;
                   end
                default: if (mem_ready) begin mm = '0; ms = 0; end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(st_ready == exp_ready(), "R6 st_ready vs model", 256'(st_ready), 256'(exp_ready()));
            chk(mem_valid == (ms == 2), "R2 mem_valid vs model", 256'(mem_valid), 256'(ms == 2));
            if (ms == 2) begin
                chk(mem_addr == {ml, 5'b0}, "R7 mem_addr vs model", 256'(mem_addr), 256'({ml, 5'b0}));
                chk(mem_mask == mm, "R7 mem_mask vs model", 256'(mem_mask), 256'(mm));
                chk(mem_data == exp_data(), "R7 mem_data vs model", mem_data, exp_data());
            end
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic store(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        forever begin
            @(negedge clk);
            if (st_ready) begin
                @(posedge clk); #1;
                st_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
    endtask

    initial begin
        int d0;
        idle(3);
        @(negedge clk);
        chk(mem_valid == 1'b0, "R1 mem_valid after reset", 256'(mem_valid), 256'(0));
        rst_n = 1'b1;
        idle(1);
        @(negedge clk);
        chk(st_ready == 1'b1, "R1 st_ready after reset", 256'(st_ready), 256'(1));
        idle(1);

        // R2: merge and overwrite inside one line, no memory traffic while gathering
        store(32'h0000_1000, 64'h1111_1111_A4A3_A2A1, 8'h0F);
        store(32'h0000_1003, 64'h2222_2222_B4B3_B2B1, 8'h03); // low bits ignored, slot 0
        store(32'h0000_1010, 64'hC800_0000_0000_0000, 8'h80);
        idle(2);
        chk(mem_valid == 1'b0, "R2 no drain while gathering", 256'(mem_valid), 256'(0));
        mem_ready = 1'b0;
        pulse_flush();
        chk(mem_valid == 1'b1, "R5 flush starts drain", 256'(mem_valid), 256'(1));
        chk(mem_data[15:0] == 16'hB2B1, "R2 overwritten bytes carry newest value",
            256'(mem_data[15:0]), 256'(16'hB2B1));
        chk(mem_mask == 32'h0080_000F, "R7 mask byte positions", 256'(mem_mask), 256'(32'h0080_000F));
        chk(mem_data[8*23 +: 8] == 8'hC8, "R7 slot 2 lane 7 is byte 23",
            256'(mem_data[8*23 +: 8]), 256'(8'hC8));
        chk(mem_addr[4:0] == 5'd0, "R7 aligned address", 256'(mem_addr), 256'(32'h1000));
        // R6: stall
        idle(4);
        chk(mem_valid == 1'b1 && st_ready == 1'b0, "R6 held during stall",
            256'({mem_valid, st_ready}), 256'(2'b10));
        mem_ready = 1'b1;
        idle(1);
        chk(mem_valid == 1'b0, "R8 empty after drain", 256'(mem_valid), 256'(0));

        // R8: fresh mask on same line
        store(32'h0000_1008, 64'h0000_0000_0000_0077, 8'h01);
        mem_ready = 1'b0;
        pulse_flush();
        chk(mem_mask == 32'h0000_0100, "R8 only new byte sent", 256'(mem_mask), 256'(32'h100));
        mem_ready = 1'b1;
        idle(2);

        // R3: fill a line completely without flush
        store(32'h0000_2000, 64'h0706_0504_0302_0100, 8'hFF);
        store(32'h0000_2010, 64'h1716_1514_1312_1110, 8'hFF);
        store(32'h0000_2018, 64'h1F1E_1D1C_1B1A_1918, 8'hFF);
        mem_ready = 1'b0;
        store(32'h0000_2008, 64'h0F0E_0D0C_0B0A_0908, 8'hFF);
        chk(mem_valid == 1'b1, "R3 drain on full", 256'(mem_valid), 256'(1));
        chk(mem_mask == 32'hFFFF_FFFF, "R3 full mask", 256'(mem_mask), 256'(32'hFFFF_FFFF));
        mem_ready = 1'b1;
        idle(2);

        // R5: flush with empty buffer
        d0 = drains;
        pulse_flush();
        idle(3);
        chk(drains == d0 && mem_valid == 1'b0, "R5 flush on empty ignored",
            256'(drains - d0), 256'(0));

        // R4: store to another line while gathering
        store(32'h0000_3000, 64'h0000_0000_0000_00AA, 8'h01);
        mem_ready = 1'b0;
        st_valid = 1'b1; st_addr = 32'h0000_4008; st_data = 64'h00BB_0000_0000_0000; st_be = 8'h40;
        @(negedge clk);
        chk(st_ready == 1'b0, "R4 foreign store held off", 256'(st_ready), 256'(0));
        idle(1);
        chk(mem_valid == 1'b1 && mem_addr == 32'h3000, "R4 old line drains",
            256'(mem_addr), 256'(32'h3000));
        mem_ready = 1'b1;
        forever begin
            @(negedge clk);
            if (st_ready) begin @(posedge clk); #1; st_valid = 1'b0; break; end
        end
        mem_ready = 1'b0;
        pulse_flush();
        chk(mem_addr == 32'h4000 && mem_mask == 32'h0000_4000, "R4 new line opened",
            256'({mem_addr, mem_mask}), 256'({32'h4000, 32'h4000}));
        mem_ready = 1'b1;
        idle(2);

        // R9: zero-enable store to foreign line while gathering
        store(32'h0000_5000, 64'h0000_0000_0000_0055, 8'h01);
        d0 = drains;
        store(32'h0000_6000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
        idle(2);
        chk(drains == d0 && mem_valid == 1'b0, "R9 zero-enable store no drain",
            256'(drains - d0), 256'(0));
        mem_ready = 1'b0;
        pulse_flush();
        chk(mem_addr == 32'h5000 && mem_mask == 32'h1, "R9 line untouched",
            256'({mem_addr, mem_mask}), 256'({32'h5000, 32'h1}));
        mem_ready = 1'b1;
        idle(2);
        // R9: zero-enable store while empty opens nothing
        store(32'h0000_7000, 64'h0, 8'h00);
        pulse_flush();
        idle(2);
        chk(mem_valid == 1'b0, "R9 empty stays empty", 256'(mem_valid), 256'(0));

        summary();
    end
endmodule